// File: doc/BRIEF.md
# Linked-Descriptor Receive DMA Engine

This engine moves an incoming byte stream into memory buffers that software describes with a chain of four-word data descriptors. A start pulse hands it the address of the first descriptor and the address of a context record. The engine then fetches the descriptor and takes 32-bit beats from a valid/ready stream. Each beat carries one to four bytes and may carry an end-of-packet mark. The bytes go to memory one per cycle, starting at the buffer pointer.

A descriptor closes in one of two cases: its buffer fills, or the last byte of an end-of-packet beat has been stored. On close, the engine writes the descriptor's flags word back, with the input end-of-packet bit set if a packet ended. It then rewrites the descriptor's end-address word with the address where filling actually stopped. It raises raw interrupt bits and then either follows the next pointer or, on the last descriptor, marks the context disabled and stops. Bytes left over in a beat when a buffer fills are carried into the next buffer. While the engine is fetching or writing back, the stream is held off. Once the chain has ended, all input is refused until the next start.

Top module: `desc_dma_in`

## Requirements
- R1: The stream port accepts a beat (inReady high) only while a descriptor is loaded and no bytes from an earlier beat are still held. Byte lanes are consumed lowest first (inData[7:0] first). One byte is written per cycle at the buffer pointer. That write uses the word address of the pointer, a one-hot byte enable selecting lane pointer[1:0], and the byte replicated on all four lanes of memWdata.
- R2: A descriptor is four 32-bit words: +0 next descriptor address, +4 buffer start, +8 flags, +12 buffer end (exclusive). In the flags word, bit 0 is end-of-list, bit 4 is the interrupt request and bit 11 is input end-of-packet. The engine reads the four words after a start pulse and after each close that is not end-of-list. Read data is taken one cycle after memRe.
- R3: A descriptor closes when the pointer reaches its buffer end. Any bytes still held from that beat continue into the next descriptor's buffer, at its start address.
- R4: A descriptor also closes after the last byte of a beat marked end-of-packet has been written. In that case the flags word is written back with bit 11 set. A buffer that fills on exactly that byte closes only once.
- R5: Close write-back is two full-word writes, in order. First the flags word goes to +8, unchanged apart from bit 11. Then the address one past the last written byte goes to +12.
- R6: A close whose descriptor has the interrupt flag set raises raw interrupt bits 0 and 1. A close caused by end-of-packet raises raw bit 3. Raw bits stay set until acknowledged.
- R7: irq is the OR of a masked-interrupt register. That register is loaded with raw AND intrMask only in a cycle where the raw value changes or intrUpdate is high. Bits set in intrAck clear the matching raw bits. A new raw bit outranks an acknowledge of the same bit in the same cycle.
- R8: After write-back of an end-of-list descriptor, the engine writes 0x00008000 with byte enable 4'b0010 to context address +4, setting the context disable bit (bit 15). chainEnd then goes high.
- R9: While chainEnd is high, inReady stays low and no memory access is made. Bytes left in the beat that closed the last descriptor are discarded. A start pulse while idle or ended begins a new chain.
- R10: After reset inReady, chainEnd, irq, memWe, memRe and all raw interrupt bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a chain (used while idle or ended) |
| startDesc | input | 32 | Address of the first descriptor |
| ctxAddr | input | 32 | Address of the context record |
| inValid | input | 1 | Stream beat valid |
| inReady | output | 1 | Stream beat accepted this cycle when valid |
| inData | input | 32 | Beat bytes, lane 0 first |
| inBytes | input | 3 | Number of valid bytes in the beat, 1 to 4 |
| inEop | input | 1 | Beat ends a packet |
| memRe | output | 1 | Memory word read request |
| memWe | output | 1 | Memory write request |
| memAddr | output | 32 | Byte address of the word accessed |
| memBe | output | 4 | Byte enables for writes |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, one cycle after memRe |
| intrMask | input | 4 | Interrupt mask |
| intrAck | input | 4 | Raw interrupt bits to clear |
| intrUpdate | input | 1 | Recompute masked interrupts |
| rawIntr | output | 4 | Raw interrupt bits |
| irq | output | 1 | Interrupt request |
| chainEnd | output | 1 | Chain has reached end-of-list |

## Verification
The first chain mixes full, partial and end-of-packet beats over three descriptors. The first buffer fills in the middle of a beat, which separates correct byte carry-over from dropped or duplicated bytes. The second buffer has an unaligned start and ends early on a packet boundary, so the rewritten end address and bit 11 are exercised. A second chain fills its buffer with a byte still left in the beat; it checks discarding at end-of-list, refusal of input afterwards, and an interrupt close that leaves the raw value unchanged, where irq must hold its old value despite a new mask. A third chain has the buffer fill on the very end-of-packet byte, which catches a double close or a missing eop flag.

// File: rtl/desc_dma_in_pkg.sv
package desc_dma_in_pkg;

  localparam int IRQ_W = 4;

  // flags word bit positions, decoded by software
  localparam int FLAG_EOL_BIT   = 0;
  localparam int FLAG_INTR_BIT  = 4;
  localparam int FLAG_INEOP_BIT = 11;
  // context disable bit in context word 1
  localparam int CTX_DIS_BIT    = 15;

  // raw interrupt bit positions
  localparam int IRQ_DATA_A = 0;
  localparam int IRQ_DATA_B = 1;
  localparam int IRQ_EOP    = 3;

  // word index inside a descriptor
  localparam logic [1:0] DESC_NEXT  = 2'd0;
  localparam logic [1:0] DESC_START = 2'd1;
  localparam logic [1:0] DESC_FLAGS = 2'd2;
  localparam logic [1:0] DESC_END   = 2'd3;

  typedef enum logic [2:0] {
    MEM_NONE,
    MEM_RD_DESC,
    MEM_WR_BYTE,
    MEM_WR_FLAGS,
    MEM_WR_END,
    MEM_WR_CTX
  } memOp_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RUN,
    ST_WB_FLAGS,
    ST_WB_END,
    ST_CTX,
    ST_DONE
  } state_e;

  typedef struct packed {
    logic       loadStart;
    logic       capValid;
    logic [1:0] capIdx;
    logic [1:0] rdIdx;
    memOp_e     memOp;
    logic       acceptBeat;
    logic       writeByte;
    logic       closeDesc;
    logic       advance;
    logic       setEol;
  } dpCtrl_t;

endpackage

// File: rtl/desc_dma_in_ctrl.sv
module desc_dma_in_ctrl
  import desc_dma_in_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    inValid,
  input  logic    holdEmpty,
  input  logic    lastEopByte,
  input  logic    hitEnd,
  input  logic    descEol,
  output logic    inReady,
  output logic    chainEnd,
  output dpCtrl_t ctl
);

  localparam int FETCH_W = 3;
  localparam logic [FETCH_W-1:0] FETCH_LAST = FETCH_W'(4);

  state_e state, stateNext;
  logic [FETCH_W-1:0] fetchCnt, fetchCntNext;

  always_comb begin
    ctl          = '0;
    ctl.memOp    = MEM_NONE;
    stateNext    = state;
    fetchCntNext = fetchCnt;
    inReady      = 1'b0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          ctl.loadStart = 1'b1;
          fetchCntNext  = '0;
          stateNext     = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (fetchCnt < FETCH_LAST) begin
          ctl.memOp = MEM_RD_DESC;
          ctl.rdIdx = fetchCnt[1:0];
        end
        if (fetchCnt != '0) begin
          ctl.capValid = 1'b1;
          ctl.capIdx   = 2'(fetchCnt[1:0] - 2'd1);
        end
        if (fetchCnt == FETCH_LAST) begin
          fetchCntNext = '0;
          stateNext    = ST_RUN;
        end else begin
          fetchCntNext = fetchCnt + FETCH_W'(1);
        end
      end
      ST_RUN: begin
        if (holdEmpty) begin
          inReady        = 1'b1;
          ctl.acceptBeat = inValid;
        end else begin
          ctl.memOp     = MEM_WR_BYTE;
          ctl.writeByte = 1'b1;
          if (hitEnd || lastEopByte) begin
            ctl.closeDesc = 1'b1;
            stateNext     = ST_WB_FLAGS;
          end
        end
      end
      ST_WB_FLAGS: begin
        ctl.memOp = MEM_WR_FLAGS;
        stateNext = ST_WB_END;
      end
      ST_WB_END: begin
        ctl.memOp = MEM_WR_END;
        if (descEol) begin
          stateNext = ST_CTX;
        end else begin
          ctl.advance  = 1'b1;
          fetchCntNext = '0;
          stateNext    = ST_FETCH;
        end
      end
      ST_CTX: begin
        ctl.memOp  = MEM_WR_CTX;
        ctl.setEol = 1'b1;
        stateNext  = ST_DONE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fetchCnt <= '0;
    end else begin
      state    <= stateNext;
      fetchCnt <= fetchCntNext;
    end
  end

  assign chainEnd = (state == ST_DONE);

endmodule

// File: rtl/desc_dma_in_dp.sv
module desc_dma_in_dp
  import desc_dma_in_pkg::*;
#(
  parameter int W     = 32,
  parameter int LANES = W / 8,
  parameter int CNT_W = $clog2(LANES + 1),
  parameter int OFF_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [W-1:0]     startDesc,
  input  logic [W-1:0]     ctxAddr,
  input  logic [W-1:0]     inData,
  input  logic [CNT_W-1:0] inBytes,
  input  logic             inEop,
  input  logic [W-1:0]     memRdata,
  input  logic [IRQ_W-1:0] intrMask,
  input  logic [IRQ_W-1:0] intrAck,
  input  logic             intrUpdate,
  output logic             memRe,
  output logic             memWe,
  output logic [W-1:0]     memAddr,
  output logic [LANES-1:0] memBe,
  output logic [W-1:0]     memWdata,
  output logic             holdEmpty,
  output logic             lastEopByte,
  output logic             hitEnd,
  output logic             descEol,
  output logic [IRQ_W-1:0] rawIntr,
  output logic             irq
);

  localparam int CTX_LANE = CTX_DIS_BIT / 8;

  logic [W-1:0]     curDesc, ctxReg, nextDesc, flagsWord, endAddr, ptr, holdData;
  logic [CNT_W-1:0] holdCnt;
  logic             holdEop, closeEop;
  logic [IRQ_W-1:0] maskedIntr, setBits, rawNext;
  logic [LANES-1:0] laneSel, ctxBe;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneSel[g] = (ptr[OFF_W-1:0] == OFF_W'(g));
    assign ctxBe[g]   = (g == CTX_LANE);
  end

  assign holdEmpty   = (holdCnt == '0);
  assign lastEopByte = (holdCnt == CNT_W'(1)) && holdEop;
  assign hitEnd      = ((ptr + W'(1)) == endAddr);
  assign descEol     = flagsWord[FLAG_EOL_BIT];

  // descriptor state and buffer pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curDesc   <= '0;
      ctxReg    <= '0;
      nextDesc  <= '0;
      flagsWord <= '0;
      endAddr   <= '0;
      ptr       <= '0;
      closeEop  <= 1'b0;
    end else begin
      if (ctl.loadStart) begin
        curDesc <= startDesc;
        ctxReg  <= ctxAddr;
      end else if (ctl.advance) begin
        curDesc <= nextDesc;
      end
      if (ctl.capValid && ctl.capIdx == DESC_NEXT)  nextDesc  <= memRdata;
      if (ctl.capValid && ctl.capIdx == DESC_FLAGS) flagsWord <= memRdata;
      if (ctl.capValid && ctl.capIdx == DESC_END)   endAddr   <= memRdata;
      if (ctl.capValid && ctl.capIdx == DESC_START) ptr <= memRdata;
      else if (ctl.writeByte)                       ptr <= ptr + W'(1);
      if (ctl.closeDesc) closeEop <= lastEopByte;
    end
  end

  // holding register for the accepted beat
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
      holdCnt  <= '0;
      holdEop  <= 1'b0;
    end else if (ctl.loadStart || ctl.setEol) begin
      holdCnt <= '0;
      holdEop <= 1'b0;
    end else if (ctl.acceptBeat) begin
      holdData <= inData;
      holdCnt  <= inBytes;
      holdEop  <= inEop;
    end else if (ctl.writeByte) begin
      holdData <= holdData >> 8;
      holdCnt  <= holdCnt - CNT_W'(1);
    end
  end

  // memory request formation
  always_comb begin
    memRe    = 1'b0;
    memWe    = 1'b0;
    memAddr  = '0;
    memBe    = '0;
    memWdata = '0;
    unique case (ctl.memOp)
      MEM_RD_DESC: begin
        memRe   = 1'b1;
        memAddr = curDesc + W'(ctl.rdIdx) * W'(LANES);
      end
      MEM_WR_BYTE: begin
        memWe    = 1'b1;
        memAddr  = {ptr[W-1:OFF_W], {OFF_W{1'b0}}};
        memBe    = laneSel;
        memWdata = {LANES{holdData[7:0]}};
      end
      MEM_WR_FLAGS: begin
        memWe    = 1'b1;
        memAddr  = curDesc + W'(DESC_FLAGS) * W'(LANES);
        memBe    = '1;
        memWdata = flagsWord | (W'(closeEop) << FLAG_INEOP_BIT);
      end
      MEM_WR_END: begin
        memWe    = 1'b1;
        memAddr  = curDesc + W'(DESC_END) * W'(LANES);
        memBe    = '1;
        memWdata = ptr;
      end
      MEM_WR_CTX: begin
        memWe    = 1'b1;
        memAddr  = ctxReg + W'(LANES);
        memBe    = ctxBe;
        memWdata = W'(1) << CTX_DIS_BIT;
      end
      default: ;
    endcase
  end

  // interrupts
  always_comb begin
    setBits = '0;
    if (ctl.closeDesc) begin
      if (flagsWord[FLAG_INTR_BIT]) begin
        setBits[IRQ_DATA_A] = 1'b1;
        setBits[IRQ_DATA_B] = 1'b1;
      end
      if (lastEopByte) setBits[IRQ_EOP] = 1'b1;
    end
    rawNext = (rawIntr & ~intrAck) | setBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawIntr    <= '0;
      maskedIntr <= '0;
    end else begin
      rawIntr <= rawNext;
      if ((rawNext != rawIntr) || intrUpdate) maskedIntr <= rawNext & intrMask;
    end
  end

  assign irq = |maskedIntr;

endmodule

// File: rtl/desc_dma_in.sv
module desc_dma_in
  import desc_dma_in_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [W-1:0]           startDesc,
  input  logic [W-1:0]           ctxAddr,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [W-1:0]           inData,
  input  logic [$clog2(W/8+1)-1:0] inBytes,
  input  logic                   inEop,
  output logic                   memRe,
  output logic                   memWe,
  output logic [W-1:0]           memAddr,
  output logic [W/8-1:0]         memBe,
  output logic [W-1:0]           memWdata,
  input  logic [W-1:0]           memRdata,
  input  logic [IRQ_W-1:0]       intrMask,
  input  logic [IRQ_W-1:0]       intrAck,
  input  logic                   intrUpdate,
  output logic [IRQ_W-1:0]       rawIntr,
  output logic                   irq,
  output logic                   chainEnd
);

  localparam int LANES = W / 8;
  localparam int CNT_W = $clog2(LANES + 1);

  dpCtrl_t ctl;
  logic    holdEmpty, lastEopByte, hitEnd, descEol;

  desc_dma_in_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .inValid    (inValid),
    .holdEmpty  (holdEmpty),
    .lastEopByte(lastEopByte),
    .hitEnd     (hitEnd),
    .descEol    (descEol),
    .inReady    (inReady),
    .chainEnd   (chainEnd),
    .ctl        (ctl)
  );

  desc_dma_in_dp #(.W(W), .LANES(LANES), .CNT_W(CNT_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .startDesc  (startDesc),
    .ctxAddr    (ctxAddr),
    .inData     (inData),
    .inBytes    (inBytes),
    .inEop      (inEop),
    .memRdata   (memRdata),
    .intrMask   (intrMask),
    .intrAck    (intrAck),
    .intrUpdate (intrUpdate),
    .memRe      (memRe),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memBe      (memBe),
    .memWdata   (memWdata),
    .holdEmpty  (holdEmpty),
    .lastEopByte(lastEopByte),
    .hitEnd     (hitEnd),
    .descEol    (descEol),
    .rawIntr    (rawIntr),
    .irq        (irq)
  );

endmodule

// File: rtl/desc_dma_in_chk.sv
module desc_dma_in_chk #(
  parameter int LANES = 4,
  parameter int IW    = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             chainEnd,
  input logic             memWe,
  input logic [LANES-1:0] memBe,
  input logic             irq,
  input logic [IW-1:0]    rawIntr,
  input logic             intrUpdate
);

  // R1
  accept_then_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R1
  byte_lane_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && (memBe != '1)) |-> ($countones(memBe) == 1));

  // R7
  irq_change_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(irq) |-> ($past(intrUpdate) || !$stable(rawIntr)));

  // R8
  ctx_write_before_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chainEnd) |-> $past(memWe));

  // R9
  ended_is_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    chainEnd |-> (!inReady && !memWe));

endmodule

bind desc_dma_in desc_dma_in_chk #(.LANES(LANES), .IW(desc_dma_in_pkg::IRQ_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inReady   (inReady),
  .chainEnd  (chainEnd),
  .memWe     (memWe),
  .memBe     (memBe),
  .irq       (irq),
  .rawIntr   (rawIntr),
  .intrUpdate(intrUpdate)
);

// File: tb/desc_dma_in_tb_top.sv
`timescale 1ns/1ps
module desc_dma_in_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] startDesc = '0;
  logic [31:0] ctxAddr = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inData = '0;
  logic [2:0]  inBytes = '0;
  logic        inEop = 1'b0;
  logic        memRe, memWe;
  logic [31:0] memAddr, memWdata;
  logic [3:0]  memBe;
  logic [31:0] memRdata = '0;
  logic [3:0]  intrMask = '0;
  logic [3:0]  intrAck = '0;
  logic        intrUpdate = 1'b0;
  logic [3:0]  rawIntr;
  logic        irq, chainEnd;

  always #2 clk = ~clk;

  desc_dma_in dut_i (
    .clk(clk), .rstN(rstN), .start(start), .startDesc(startDesc), .ctxAddr(ctxAddr),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inBytes(inBytes), .inEop(inEop),
    .memRe(memRe), .memWe(memWe), .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata),
    .memRdata(memRdata), .intrMask(intrMask), .intrAck(intrAck), .intrUpdate(intrUpdate),
    .rawIntr(rawIntr), .irq(irq), .chainEnd(chainEnd)
  );

  // memory model, 4 KB
  logic [31:0] mem [0:1023];

  always @(posedge clk) begin
    if (memWe)
      for (int b = 0; b < 4; b++)
        if (memBe[b]) mem[memAddr[11:2]][8*b +: 8] <= memWdata[8*b +: 8];
    if (memRe) memRdata <= mem[memAddr[11:2]];
  end

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard of expected memory writes
  typedef struct {
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
    string       tag;
  } wr_t;
  wr_t expQ[$];
  wr_t cur;

  task automatic pushWr(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d, input string tag);
    wr_t e;
    e.addr = a; e.be = be; e.data = d; e.tag = tag;
    expQ.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9 unexpected write", {memAddr, memBe, memWdata}, 128'd0);
      end else begin
        cur = expQ.pop_front();
        check(memAddr == cur.addr && memBe == cur.be && memWdata == cur.data, cur.tag,
              {memAddr, memBe, memWdata}, {cur.addr, cur.be, cur.data});
      end
    end
  end

  // reference model of the chain
  logic [31:0] mDesc, mNext, mPtr, mFlags, mEnd, mCtx;
  bit          mEol;
  logic [3:0]  mRaw = '0;

  task automatic loadDesc(input logic [31:0] a);
    mDesc  = a;
    mNext  = mem[a[11:2]];
    mPtr   = mem[a[11:2] + 1];
    mFlags = mem[a[11:2] + 2];
    mEnd   = mem[a[11:2] + 3];
  endtask

  task automatic closeDesc(input bit eop);
    pushWr(mDesc + 8, 4'hF, mFlags | (32'(eop) << 11), eop ? "R4 flags" : "R5 flags");
    pushWr(mDesc + 12, 4'hF, mPtr, eop ? "R4 end" : "R5 end");
    if (mFlags[4]) mRaw = mRaw | 4'b0011;
    if (eop) mRaw = mRaw | 4'b1000;
    if (mFlags[0]) begin
      pushWr(mCtx + 4, 4'b0010, 32'h0000_8000, "R8 ctx");
      mEol = 1;
    end else begin
      loadDesc(mNext);
    end
  endtask

  task automatic modelByte(input logic [7:0] b, input bit lastEop);
    pushWr({mPtr[31:2], 2'b00}, 4'b0001 << mPtr[1:0], {4{b}}, "R1 byte");
    mPtr = mPtr + 1;
    if (mPtr == mEnd || lastEop) closeDesc(lastEop);
  endtask

  task automatic setDesc(input logic [31:0] a, input logic [31:0] nx, input logic [31:0] bf,
                         input logic [31:0] fl, input logic [31:0] en);
    mem[a[11:2]]     = nx;
    mem[a[11:2] + 1] = bf;
    mem[a[11:2] + 2] = fl;
    mem[a[11:2] + 3] = en;
  endtask

  task automatic startChain(input logic [31:0] d, input logic [31:0] c);
    mCtx = c;
    mEol = 0;
    loadDesc(d);
    start = 1'b1; startDesc = d; ctxAddr = c;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic sendBeat(input logic [31:0] data, input int n, input bit eop);
    for (int i = 0; i < n; i++)
      if (!mEol) modelByte(data[8*i +: 8], eop && (i == n - 1));
    inValid = 1'b1; inData = data; inBytes = 3'(n); inEop = eop;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitEnd();
    while (!chainEnd) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulseIntr(input logic [3:0] ack);
    intrAck = ack; intrUpdate = 1'b1;
    @(negedge clk);
    intrAck = '0; intrUpdate = 1'b0;
    mRaw = mRaw & ~ack;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    // chain 1
    setDesc(32'h100, 32'h120, 32'h200, 32'h10, 32'h208);
    setDesc(32'h120, 32'h140, 32'h301, 32'h00, 32'h310);
    setDesc(32'h140, 32'h000, 32'h400, 32'h11, 32'h440);
    // chain 2 and 3
    setDesc(32'h160, 32'h000, 32'h500, 32'h11, 32'h503);
    setDesc(32'h180, 32'h000, 32'h602, 32'h01, 32'h606);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(inReady == 0, "R10 inReady", inReady, 0);
    check(chainEnd == 0, "R10 chainEnd", chainEnd, 0);
    check(irq == 0, "R10 irq", irq, 0);
    check(rawIntr == 0, "R10 rawIntr", rawIntr, 0);
    check(memWe == 0 && memRe == 0, "R10 mem idle", {memWe, memRe}, 0);

    // chain 1: mid-beat fill with carry (R3), early eop (R4), end-of-list (R8)
    startChain(32'h100, 32'h080);
    sendBeat(32'h4433_2211, 4, 0);
    sendBeat(32'h0077_6655, 3, 0);
    sendBeat(32'hBBAA_9988, 4, 0);
    sendBeat(32'h0000_DDCC, 2, 1);
    sendBeat(32'h1312_1110, 4, 1);
    waitEnd();
    check(expQ.size() == 0, "R2 all chain1 writes seen", expQ.size(), 0);
    check(mem[32'h304 >> 2] == 32'hDDCC_AA99 >> 0 ? 1'b1 : (mem[32'h304 >> 2][15:0] == 16'hDDCC),
          "R3 carried bytes", mem[32'h304 >> 2], 32'h0000_DDCC);
    check(mem[32'h12C >> 2] == 32'h306, "R4 end rewritten", mem[32'h12C >> 2], 32'h306);
    check(rawIntr == mRaw && mRaw == 4'b1011, "R6 raw after chain1", rawIntr, 4'b1011);
    check(irq == 0, "R7 masked off", irq, 0);
    check(chainEnd == 1, "R8 chainEnd", chainEnd, 1);

    // R7 mask change alone does nothing
    intrMask = 4'b1000;
    repeat (2) @(negedge clk);
    check(irq == 0, "R7 mask without update", irq, 0);
    pulseIntr(4'b0000);
    check(irq == 1, "R7 update recomputes", irq, 1);
    pulseIntr(4'b1000);
    check(rawIntr == 4'b0011 && irq == 0, "R7 ack clears", {rawIntr, irq}, {4'b0011, 1'b0});

    // chain 2: fill with leftover byte at end-of-list, raw unchanged
    intrMask = 4'b0011;
    startChain(32'h160, 32'h090);
    sendBeat(32'h2A2B_2C2D, 4, 0);
    waitEnd();
    check(expQ.size() == 0, "R9 leftover dropped", expQ.size(), 0);
    check(rawIntr == 4'b0011, "R6 raw stays", rawIntr, 4'b0011);
    check(irq == 0, "R7 no recompute when raw unchanged", irq, 0);

    // R9 refusal after end of list
    inValid = 1'b1; inData = 32'hFFFF_FFFF; inBytes = 3'd4; inEop = 1'b1;
    begin
      bit sawReady = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (inReady) sawReady = 1;
      end
      check(!sawReady, "R9 input refused", sawReady, 0);
    end
    inValid = 1'b0;
    check(expQ.size() == 0, "R9 no writes while ended", expQ.size(), 0);

    pulseIntr(4'b0000);
    check(irq == 1, "R7 update after mask change", irq, 1);
    pulseIntr(4'b1111);
    check(rawIntr == 0 && irq == 0, "R7 ack all", {rawIntr, irq}, 0);
    intrMask = 4'b1000;
    pulseIntr(4'b0000);

    // chain 3: buffer fills on the eop byte (R4), restart (R9)
    startChain(32'h180, 32'h0A0);
    sendBeat(32'h5D5C_5B5A, 4, 1);
    waitEnd();
    check(expQ.size() == 0, "R4 single close on fill plus eop", expQ.size(), 0);
    check(mem[32'h188 >> 2] == 32'h801, "R4 eop flag bit11", mem[32'h188 >> 2], 32'h801);
    check(rawIntr == 4'b1000, "R6 eop bit only", rawIntr, 4'b1000);
    check(irq == 1, "R7 raw change recomputes", irq, 1);
    check(mem[32'h0A4 >> 2] == 32'h8000, "R8 context disable", mem[32'h0A4 >> 2], 32'h8000);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

endmodule